// File: doc/BRIEF.md
# Quad-Pumped Inverted Data Receiver

This block receives a 64-bit data bus that moves four beats in each common clock period. The bus is split into four 16-bit lanes. Each lane has its own pair of source-synchronous strobes, a P strobe and an N strobe, and its own inversion flag. On a falling edge of either strobe, a lane captures its 16 pins. The pins are active-low, so the lane flips them. If the lane's inversion flag is set on that same edge, the lane flips them once more. A P-strobe fall fills beat 0 and then beat 2. An N-strobe fall fills beat 1 and then beat 3. An edge is taken only while the driver's data-ready input is high.

When the fourth beat lands in a lane, that lane sends a completion toggle to the common clock domain. Once all four lanes have reported, the 256-bit line is registered there and a one-cycle valid pulse marks it. Beat 0 sits in the least significant 64 bits. The strobe-domain state clears through a synchronous reset. The reset is sampled on strobe falling edges, so the strobes must fall at least once while reset is high.

Top module: `qp_inv_rx`

## Requirements
- R1: While `rst` is high and on the first clock after it, `line_vld` is 0 and `line_out` is all zeros.
- R2: Data pins are active-low. With the lane's inversion flag low, the captured beat equals the bitwise complement of the lane's 16 pins.
- R3: With a lane's inversion flag high on the capturing edge, the captured beat equals the lane's 16 pins as driven. Each lane's flag is sampled on its own strobe edge and affects only that beat of that lane.
- R4: Lane g (g = 0..3) uses pins `d_n[16g+15:16g]`, strobes `stb_p[g]` and `stb_n[g]`, and flag `inv[g]`. Its beats land in bits `[64b+16g+15 : 64b+16g]` of `line_out` for beat b.
- R5: Within a lane, the first and second P-strobe falls capture beats 0 and 2, and the first and second N-strobe falls capture beats 1 and 3. Beat b occupies `line_out[64b+63:64b]`.
- R6: A strobe fall while `rdy` is low captures nothing and does not advance the lane's beat position.
- R7: Each completed transfer, meaning every lane has taken four beats, gives exactly one `line_vld` pulse one clock wide.
- R8: No pulse is produced while any lane is still short of four beats. When the last lane completes, the line carries the earlier lanes' data together with the late lane's data.
- R9: `line_out` changes only in a cycle where `line_vld` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset, also sampled on strobe falls |
| stb_p | input | 4 | P strobe per lane, falling edge captures even beats |
| stb_n | input | 4 | N strobe per lane, falling edge captures odd beats |
| d_n | input | 64 | Active-low data pins, four 16-bit lanes |
| inv | input | 4 | Per-lane inversion flag, high means the lane is sent inverted |
| rdy | input | 1 | Driver data-ready; strobe edges count only while high |
| line_out | output | 256 | Assembled four-beat line, beat 0 in the low 64 bits |
| line_vld | output | 1 | One-cycle pulse when `line_out` holds a new line |

## Verification
A lane whose beat position has slipped does not stall. It completes one strobe edge early or late, so the next line shows its 16-bit slices swapped between beat slots, or the valid pulse is missing or comes one transfer too soon. A wrong inversion or polarity state shows as whole 16-bit slices complemented in the very next line. A lost or doubled completion toggle shows within a few clocks of the transfer as a missing pulse or an extra one. Every such fault therefore appears at `line_out`/`line_vld` no later than the transfer after the one that went wrong.

// File: rtl/qp_rx_pkg.sv
package qp_rx_pkg;
  localparam int unsigned QP_LANES  = 4;
  localparam int unsigned QP_LANE_W = 16;
  localparam int unsigned QP_BEATS  = 4;

  function automatic int unsigned qp_cw(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/qp_lane_cap.sv
module qp_lane_cap
  import qp_rx_pkg::*;
#(
  parameter int unsigned LANE_W = QP_LANE_W,
  parameter int unsigned BEATS  = QP_BEATS
) (
  input  logic                    rst,
  input  logic                    stb_p,
  input  logic                    stb_n,
  input  logic                    rdy,
  input  logic                    inv,
  input  logic [LANE_W-1:0]       pins_n,
  output logic [BEATS*LANE_W-1:0] beats,
  output logic                    done_tgl
);
  localparam int unsigned HALF = BEATS / 2;
  localparam int unsigned CW   = qp_cw(HALF);

  logic [LANE_W-1:0] p_q [HALF];
  logic [LANE_W-1:0] n_q [HALF];
  logic [CW-1:0]     p_pos, n_pos;
  logic [LANE_W-1:0] restored;

  // active-low pins, then undo optional inversion
  assign restored = ~pins_n ^ {LANE_W{inv}};

  always_ff @(negedge stb_p) begin
    if (rst) begin
      p_pos <= '0;
      for (int k = 0; k < int'(HALF); k++) p_q[k] <= '0;
    end else if (rdy) begin
      p_q[p_pos] <= restored;
      p_pos      <= (p_pos == CW'(HALF-1)) ? '0 : p_pos + 1'b1;
    end
  end

  always_ff @(negedge stb_n) begin
    if (rst) begin
      n_pos    <= '0;
      done_tgl <= 1'b0;
      for (int k = 0; k < int'(HALF); k++) n_q[k] <= '0;
    end else if (rdy) begin
      n_q[n_pos] <= restored;
      if (n_pos == CW'(HALF-1)) begin
        n_pos    <= '0;
        done_tgl <= ~done_tgl;
      end else begin
        n_pos <= n_pos + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < int'(HALF); k++) begin : g_slot
    assign beats[(2*k)*LANE_W   +: LANE_W] = p_q[k];
    assign beats[(2*k+1)*LANE_W +: LANE_W] = n_q[k];
  end
endmodule

// File: rtl/qp_tgl_sync.sv
module qp_tgl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], tgl_in};
  end

  assign pulse = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/qp_inv_rx.sv
module qp_inv_rx
  import qp_rx_pkg::*;
#(
  parameter int unsigned LANES  = QP_LANES,
  parameter int unsigned LANE_W = QP_LANE_W,
  parameter int unsigned BEATS  = QP_BEATS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [LANES-1:0]               stb_p,
  input  logic [LANES-1:0]               stb_n,
  input  logic [LANES*LANE_W-1:0]        d_n,
  input  logic [LANES-1:0]               inv,
  input  logic                           rdy,
  output logic [LANES*LANE_W*BEATS-1:0]  line_out,
  output logic                           line_vld
);
  localparam int unsigned BUS_W  = LANES * LANE_W;
  localparam int unsigned LINE_W = BUS_W * BEATS;

  logic [BEATS*LANE_W-1:0] lane_beats [LANES];
  logic [LANES-1:0]        lane_tgl;
  logic [LANES-1:0]        lane_done;
  logic [LANES-1:0]        pending;
  logic                    all_pend;
  logic [LINE_W-1:0]       line_next;

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    qp_lane_cap #(.LANE_W(LANE_W), .BEATS(BEATS)) u_cap (
      .rst     (rst),
      .stb_p   (stb_p[g]),
      .stb_n   (stb_n[g]),
      .rdy     (rdy),
      .inv     (inv[g]),
      .pins_n  (d_n[g*LANE_W +: LANE_W]),
      .beats   (lane_beats[g]),
      .done_tgl(lane_tgl[g])
    );

    qp_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .tgl_in(lane_tgl[g]),
      .pulse (lane_done[g])
    );

    for (genvar b = 0; b < int'(BEATS); b++) begin : g_beat
      assign line_next[b*BUS_W + g*LANE_W +: LANE_W] = lane_beats[g][b*LANE_W +: LANE_W];
    end
  end

  assign all_pend = &pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= '0;
      line_vld <= 1'b0;
      line_out <= '0;
    end else begin
      pending  <= all_pend ? lane_done : (pending | lane_done);
      line_vld <= all_pend;
      if (all_pend) line_out <= line_next;
    end
  end
endmodule

// File: rtl/qp_inv_rx_chk.sv
module qp_inv_rx_chk #(
  parameter int unsigned LINE_W = 256,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [LINE_W-1:0] line_out,
  input logic              line_vld,
  input logic [LANES-1:0]  pending
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!line_vld && line_out == '0));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    line_vld |=> !line_vld);

  assert_pend_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (&pending) |=> !(&pending));

  assert_line_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !line_vld |-> $stable(line_out));
endmodule

bind qp_inv_rx qp_inv_rx_chk #(.LINE_W(LINE_W), .LANES(LANES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .line_out(line_out),
  .line_vld(line_vld),
  .pending (pending)
);

// File: tb/sim_qp_inv_rx.sv
`timescale 1ns/1ps
module sim_qp_inv_rx;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   stb_p = 4'hF;
  logic [3:0]   stb_n = 4'hF;
  logic [63:0]  d_n = '0;
  logic [3:0]   inv = '0;
  logic         rdy = 1'b1;
  logic [255:0] line_out;
  logic         line_vld;

  int total = 0;
  int bad   = 0;
  int pulses = 0;
  logic [255:0] got = '0;
  logic [255:0] mdl = '0;
  logic [63:0]  lv  [4];
  logic [3:0]   ivv [4];

  always #4 clk = ~clk;

  qp_inv_rx u0 (
    .clk(clk), .rst(rst), .stb_p(stb_p), .stb_n(stb_n), .d_n(d_n),
    .inv(inv), .rdy(rdy), .line_out(line_out), .line_vld(line_vld)
  );

  always @(negedge clk) begin
    if (!rst && line_vld) begin
      pulses++;
      got = line_out;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive_beat(input int b);
    for (int g = 0; g < 4; g++)
      d_n[16*g +: 16] = ~(lv[b][16*g +: 16] ^ {16{ivv[b][g]}});
    inv = ivv[b];
  endtask

  // one transfer on the lanes in mask; ign inserts a strobe fall with rdy low (R6)
  task automatic xfer(input logic [3:0] mask, input bit ign);
    drive_beat(0); #2 stb_p &= ~mask; #2;
    drive_beat(1); #2 stb_n &= ~mask; #2 stb_p |= mask; #2;
    if (ign) begin
      rdy = 1'b0; d_n = {$urandom, $urandom}; inv = 4'($urandom);
      #2 stb_p &= ~mask; #2 stb_p |= mask; #2 rdy = 1'b1;
    end
    drive_beat(2); #2 stb_p &= ~mask; #2 stb_n |= mask; #2;
    drive_beat(3); #2 stb_n &= ~mask; #2;
    stb_p |= mask; stb_n |= mask; #2;
    for (int b = 0; b < 4; b++)
      for (int g = 0; g < 4; g++)
        if (mask[g]) mdl[64*b + 16*g +: 16] = lv[b][16*g +: 16];
  endtask

  task automatic settle_and_check(input int exp_pulses, input string req);
    int p0;
    p0 = pulses;
    repeat (12) @(negedge clk);
    chk(pulses - p0 == exp_pulses, {req, " pulse count"}, 256'(pulses - p0), 256'(exp_pulses));
    if (exp_pulses > 0) begin
      chk(got == mdl, req, got, mdl);
      chk(line_out == got, "R9 hold", line_out, got);
    end
  endtask

  task automatic fill(input bit rnd_inv, input logic [3:0] fixed_inv);
    for (int b = 0; b < 4; b++) begin
      lv[b]  = {$urandom, $urandom};
      ivv[b] = rnd_inv ? 4'($urandom) : fixed_inv;
    end
  endtask

  initial begin
    #1_600_000;
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (2) begin
      #3 stb_p = '0; stb_n = '0; #3 stb_p = '1; stb_n = '1;
    end
    repeat (3) @(negedge clk);
    chk(line_vld == 1'b0, "R1 vld in reset", 256'(line_vld), 256'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(line_vld == 1'b0 && line_out == '0, "R1 after reset", line_out, '0);

    // R2: no inversion, fixed pattern per beat/lane
    for (int b = 0; b < 4; b++) begin
      lv[b] = {16'(16'h1000 + 16*b + 3), 16'(16'h1000 + 16*b + 2),
               16'(16'h1000 + 16*b + 1), 16'(16'h1000 + 16*b)};
      ivv[b] = 4'h0;
    end
    xfer(4'hF, 1'b0); settle_and_check(1, "R2 R4 R5 plain");

    // R3: all lanes inverted
    fill(1'b0, 4'hF); xfer(4'hF, 1'b0); settle_and_check(1, "R3 all inverted");

    // R3/R4: alternating lanes inverted, varies per beat
    for (int b = 0; b < 4; b++) begin lv[b] = {$urandom, $urandom}; ivv[b] = (b % 2) ? 4'h5 : 4'hA; end
    xfer(4'hF, 1'b0); settle_and_check(1, "R3 R4 mixed flags");

    // R6: ignored strobe fall while rdy low
    fill(1'b1, 4'h0); xfer(4'hF, 1'b1); settle_and_check(1, "R6 rdy low ignored");

    // R8: lane 3 left short, then completed alone
    fill(1'b1, 4'h0); xfer(4'h7, 1'b0); settle_and_check(0, "R8 partial no pulse");
    fill(1'b1, 4'h0); xfer(4'h8, 1'b0); settle_and_check(1, "R8 late lane");

    // random transfers (R2 R3 R5 R7)
    for (int t = 0; t < 12; t++) begin
      fill(1'b1, 4'h0);
      xfer(4'hF, (t % 3) == 0);
      settle_and_check(1, "R7 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule